// File: doc/BRIEF.md
# SPI Shared-Buffer Transaction Engine

This block is a register-mapped SPI master for single-data-line flash commands. Every byte of a transaction passes through one small word-addressed buffer. Software first packs the outgoing bytes into the buffer: the opcode, then the address with its most significant byte first, then any dummy bytes, then any write data. It then programs an outgoing byte count and an incoming byte count and writes the control register with trigger and enable set. The engine asserts chip select and shifts the outgoing bytes out in SPI mode 0. It keeps the clock running for the requested number of incoming bytes and writes each received byte back into the same buffer, directly after the last outgoing byte.

The control register reports two status bits. Ready rises when a trigger is accepted. In-progress stays high until the last received byte is stored and chip select is released. Software closes a transaction by clearing trigger and enable together. A soft-reset bit forces the serial state machine to idle, and a state register reads nonzero whenever that machine is active.

Register word addresses:

| Word | Contents |
|---|---|
| 0 | control |
| 1 | outgoing count |
| 2 | incoming count |
| 3 | clock half-period |
| 4 | soft reset, bit 0 |
| 5 | serial state, read-only |
| 64 + n | buffer word n |

The SPI clock half-period is the clock half-period register in system clocks. A value of 0 is treated as 1, so the smallest divide is 2.

Top module: `spi_xfer_buf`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the state register (address 5) reads 0, chip select is high and SCK is low.
- R2: Buffer word n sits at register address 64+n and reads back what was written. Byte k of the stream is bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4, so byte 0 is bits 7:0 of word 0.
- R3: Outgoing bytes leave on MOSI in buffer order from byte 0, most significant bit first. MOSI is stable while SCK is high. SCK rises only while chip select is low.
- R4: Incoming bytes are assembled most significant bit first. The first one is stored at byte position equal to the outgoing count, and each later one at the next position.
- R5: With an incoming count of 0, exactly 8 times the outgoing count SCK pulses occur, and no buffer byte beyond the outgoing bytes changes.
- R6: A control write with bit 2 (trigger) and bit 3 (enable) set and bit 4 clear is accepted as a start only when trigger was previously clear and the engine is idle. An accepted start sets ready (bit 1) and in-progress (bit 0). In-progress never stands without ready.
- R7: In-progress clears only after the last incoming byte is stored, at the same cycle that chip select rises. Ready stays set until software clears it.
- R8: A control write with trigger and enable both clear drops ready and in-progress, stops any transfer and raises chip select.
- R9: A trigger whose outgoing plus incoming count exceeds 160 leaves ready and in-progress clear and causes no chip-select activity. A total of exactly 160 is accepted.
- R10: A trigger with an outgoing count of 0 sets ready, never sets in-progress and causes no chip-select activity.
- R11: A trigger written with bit 4 (serial I/O mode) set does not start a transfer.
- R12: While the soft-reset bit (address 4, bit 0) is 1, the serial machine is held idle, chip select is high and in-progress is clear. The state register is nonzero during a transfer.
- R13: While in-progress is set, bus writes to the buffer and to the count and clock registers are ignored.
- R14: Chip select falls three SCK half-periods before the first SCK rise, and successive SCK rises are two half-periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench aims at where incoming bytes land when the outgoing count is not a multiple of four. A design that restarted reception at a word boundary, or at byte 0, would overwrite command bytes or scatter the reply across the wrong lanes. It also probes the length limit at exactly 160 and at 161: an off-by-one check would either refuse a legal maximal transfer or start one that overruns the buffer. Zero outgoing count, the serial I/O mode bit, buffer writes during a transfer, abort and soft reset in mid-frame are each driven directly. A wrong design would emit stray chip-select pulses, corrupt the buffer, or leave in-progress stuck high.

// File: rtl/spi_xfer_buf.sv
module spi_xfer_buf #(
  parameter int BUF_BYTES = 160,
  parameter int ADDR_W    = 7,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int WORDS  = (BUF_BYTES + 3) / 4;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int BIT_W  = $clog2(BUF_BYTES * 8);
  localparam int BYTE_W = BIT_W - 3;
  localparam logic [WIDX_W:0] WORDS_L = (WIDX_W + 1)'(WORDS);
  localparam logic [CNT_W:0]  MAX_L   = (CNT_W + 1)'(BUF_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL} st_t;

  logic [31:0]       mem [WORDS];
  logic              busy, rdy, trig, en, sio, srst, phase;
  logic [CNT_W-1:0]  txlen, rxlen;
  logic [DIV_W-1:0]  div, divcnt;
  logic [BIT_W-1:0]  bitcnt;
  logic [6:0]        sr;
  st_t               state;

  logic [WIDX_W-1:0] widx;
  logic              buf_hit;
  assign widx    = reg_addr[WIDX_W-1:0];
  assign buf_hit = reg_addr[ADDR_W-1] && ({1'b0, widx} < WORDS_L);

  logic              ctrl_wr, start_req, abort, go, nop, too_long;
  logic [CNT_W:0]    total;
  assign ctrl_wr   = reg_we && (reg_addr == ADDR_W'(0));
  assign total     = {1'b0, txlen} + {1'b0, rxlen};
  assign too_long  = total > MAX_L;
  assign start_req = ctrl_wr && reg_wdata[2] && reg_wdata[3] && !reg_wdata[4]
                     && !trig && (state == S_IDLE) && !busy && !srst;
  assign abort     = ctrl_wr && !reg_wdata[2] && !reg_wdata[3];
  assign go        = start_req && !too_long && (txlen != '0);
  assign nop       = start_req && !too_long && (txlen == '0);

  logic [DIV_W-1:0] div_eff;
  logic             tick;
  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick    = (state != S_IDLE) && (divcnt == div_eff - DIV_W'(1));

  logic [BYTE_W-1:0] cur_byte;
  logic [WIDX_W-1:0] cur_w;
  logic [1:0]        lane;
  logic              in_tx, last, rx_store;
  logic [31:0]       tx_word;
  logic [7:0]        tx_byte;
  logic [BIT_W-1:0]  last_bit;
  assign cur_byte = bitcnt[BIT_W-1:3];
  assign cur_w    = WIDX_W'(cur_byte >> 2);
  assign lane     = cur_byte[1:0];
  assign in_tx    = 32'(cur_byte) < 32'(txlen);
  assign tx_word  = mem[cur_w];
  assign tx_byte  = tx_word[{lane, 3'b000} +: 8];
  assign last_bit = BIT_W'({total, 3'b000} - 1'b1);
  assign last     = bitcnt == last_bit;
  assign rx_store = tick && (state == S_SHIFT) && !spi_sck && !in_tx && (bitcnt[2:0] == 3'd7);
  assign spi_mosi = (state == S_SHIFT) && in_tx && tx_byte[~bitcnt[2:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rdy <= 1'b0; trig <= 1'b0; en <= 1'b0; sio <= 1'b0;
      srst <= 1'b0; phase <= 1'b0; txlen <= '0; rxlen <= '0; div <= '0;
      divcnt <= '0; bitcnt <= '0; sr <= '0; state <= S_IDLE;
      spi_sck <= 1'b0; spi_cs_n <= 1'b1;
    end else begin
      if (ctrl_wr) {sio, en, trig} <= reg_wdata[4:2];
      if (reg_we && !busy && reg_addr == ADDR_W'(1)) txlen <= reg_wdata[CNT_W-1:0];
      if (reg_we && !busy && reg_addr == ADDR_W'(2)) rxlen <= reg_wdata[CNT_W-1:0];
      if (reg_we && !busy && reg_addr == ADDR_W'(3)) div   <= reg_wdata[DIV_W-1:0];
      if (reg_we && reg_addr == ADDR_W'(4))          srst  <= reg_wdata[0];

      divcnt <= (state == S_IDLE || tick) ? '0 : divcnt + DIV_W'(1);

      if (go) begin
        rdy <= 1'b1; busy <= 1'b1; state <= S_LEAD;
        spi_cs_n <= 1'b0; phase <= 1'b0; bitcnt <= '0;
      end else if (nop) begin
        rdy <= 1'b1;
      end

      if (tick) begin
        case (state)
          S_LEAD: begin
            phase <= ~phase;
            if (phase) state <= S_SHIFT;
          end
          S_SHIFT: begin
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              if (!in_tx) sr <= {sr[5:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              if (last) begin
                state <= S_TAIL; phase <= 1'b0;
              end else begin
                bitcnt <= bitcnt + BIT_W'(1);
              end
            end
          end
          S_TAIL: begin
            phase <= ~phase;
            if (phase) begin
              state <= S_IDLE; spi_cs_n <= 1'b1; busy <= 1'b0;
            end
          end
          default: ;
        endcase
      end

      if (abort || srst) begin
        rdy <= 1'b0; busy <= 1'b0; state <= S_IDLE;
        spi_cs_n <= 1'b1; spi_sck <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (reg_we && buf_hit && !busy) mem[widx] <= reg_wdata;
      if (rx_store) mem[cur_w][{lane, 3'b000} +: 8] <= {sr, spi_miso};
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(0): reg_rdata = {27'b0, sio, en, trig, rdy, busy};
      ADDR_W'(1): reg_rdata = 32'(txlen);
      ADDR_W'(2): reg_rdata = 32'(rxlen);
      ADDR_W'(3): reg_rdata = 32'(div);
      ADDR_W'(4): reg_rdata = {31'b0, srst};
      ADDR_W'(5): reg_rdata = {30'b0, state};
      default:    reg_rdata = buf_hit ? mem[widx] : 32'b0;
    endcase
  end
endmodule

// File: rtl/spi_xfer_buf_chk.sv
module spi_xfer_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic       busy,
  input logic       rdy,
  input logic       srst,
  input logic [1:0] state
);
  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> spi_cs_n);

  assert_sck_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> !spi_cs_n);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_busy_has_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rdy);

  assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !busy);

  assert_srst_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (state == 2'd0 && spi_cs_n && !busy));
endmodule

bind spi_xfer_buf spi_xfer_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .busy(busy), .rdy(rdy), .srst(srst), .state(state)
);

// File: tb/spi_xfer_buf_bench.sv
`timescale 1ns/1ps
module spi_xfer_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  spi_xfer_buf u_spi_xfer_buf (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cur_seed = 0;
  int s_pos = 0, cs_falls = 0, cs_fall_cyc = 0, first_rise = 0, last_rise = 0, period = 0;
  logic [7:0] cap [160];

  localparam int NV = 7;
  localparam int V_TX   [NV] = '{1, 4, 5, 3, 6, 2, 4};
  localparam int V_RX   [NV] = '{0, 4, 3, 9, 0, 1, 156};
  localparam int V_SEED [NV] = '{17, 90, 195, 7, 225, 60, 153};
  localparam int V_DIV  [NV] = '{1, 1, 2, 1, 3, 4, 1};

  function automatic logic [7:0] txb(int seed, int i);
    return 8'((seed + i * 29 + 3) & 255);
  endfunction
  function automatic logic [7:0] rxb(int seed, int p);
    return 8'((seed * 7 + p * 13 + 91) & 255);
  endfunction
  function automatic logic rxbit(int p);
    logic [7:0] b;
    b = rxb(cur_seed, p >> 3);
    return b[7 - (p & 7)];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) act=%0d exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge spi_cs_n) begin
    s_pos = 0; cs_falls++; cs_fall_cyc = cyc; first_rise = 0;
    miso = rxbit(0);
  end
  always @(posedge spi_sck) begin
    if (s_pos < 1280) cap[s_pos >> 3][7 - (s_pos & 7)] = spi_mosi;
    if (s_pos == 0) first_rise = cyc; else period = cyc - last_rise;
    last_rise = cyc;
    s_pos++;
  end
  always @(negedge spi_sck) begin
    #1 miso = rxbit(s_pos);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 7'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 40000; i++) begin
      rd(0, d);
      if (!d[0]) break;
    end
  endtask

  task automatic read_byte(input int q, output logic [7:0] b);
    logic [31:0] d;
    rd(64 + q / 4, d);
    b = d[8 * (q % 4) +: 8];
  endtask

  task automatic run_vec(input int tx, input int rx, input int seed, input int dv);
    logic [31:0] d, w;
    logic [7:0]  b;
    cur_seed = seed;
    for (int k = 0; k < 40; k++) begin
      w = '0;
      for (int j = 0; j < 4; j++) if (4 * k + j < tx) w[8 * j +: 8] = txb(seed, 4 * k + j);
      wr(64 + k, w);
    end
    wr(1, 32'(tx)); wr(2, 32'(rx)); wr(3, 32'(dv));
    wr(0, 32'hC);
    rd(0, d);  check("R6 start sets ready and in-progress", d, 32'h0F);
    wait_idle();
    rd(0, d);  check("R7 in-progress clear, ready held", d, 32'h0E);
    check("R7 chip select released", 32'(spi_cs_n), 32'd1);
    check(rx == 0 ? "R5 SCK pulse count" : "R3 SCK pulse count", 32'(s_pos), 32'((tx + rx) * 8));
    for (int i = 0; i < tx; i++) check("R3 wire byte", 32'(cap[i]), 32'(txb(seed, i)));
    for (int p = 0; p < rx; p++) begin
      read_byte(tx + p, b);
      check("R4 received byte placement", 32'(b), 32'(rxb(seed, tx + p)));
    end
    if (rx == 0)
      for (int q = tx; q < tx + 4 && q < 160; q++) begin
        read_byte(q, b);
        check("R5 bytes after outgoing untouched", 32'(b), 32'd0);
      end
    check("R14 chip-select lead", 32'(first_rise - cs_fall_cyc), 32'(3 * dv));
    if (tx + rx > 1) check("R14 SCK period", 32'(period), 32'(2 * dv));
    wr(0, 0);
    rd(0, d);  check("R8 clear returns idle", d, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, d); check("R1 control after reset", d, 32'h0);
    rd(5, d); check("R1 state after reset", d, 32'h0);
    check("R1 chip select after reset", 32'(spi_cs_n), 32'd1);
    check("R1 SCK after reset", 32'(spi_sck), 32'd0);

    for (int v = 0; v < NV; v++) run_vec(V_TX[v], V_RX[v], V_SEED[v], V_DIV[v]);

    wr(64 + 7, 32'hA1B2C3D4);
    rd(64 + 7, d); check("R2 buffer word readback", d, 32'hA1B2C3D4);
    cur_seed = 0;
    wr(64, 32'h44332211); wr(1, 4); wr(2, 0); wr(3, 1); wr(0, 32'hC);
    wait_idle();
    check("R2 byte 0 from bits 7:0", 32'(cap[0]), 32'h11);
    check("R2 byte 3 from bits 31:24", 32'(cap[3]), 32'h44);
    wr(0, 0);

    f0 = cs_falls;
    wr(1, 0); wr(2, 3); wr(0, 32'hC);
    rd(0, d); check("R10 zero outgoing count: ready only", d, 32'h0E);
    repeat (20) @(negedge clk);
    rd(0, d); check("R10 in-progress never set", d, 32'h0E);
    check("R10 no chip-select activity", 32'(cs_falls), 32'(f0));
    wr(0, 0);

    wr(1, 100); wr(2, 61); wr(0, 32'hC);
    rd(0, d); check("R9 over-length rejected", d, 32'h0C);
    repeat (20) @(negedge clk);
    check("R9 no chip-select activity", 32'(cs_falls), 32'(f0));
    wr(0, 0);

    wr(1, 2); wr(2, 0); wr(0, 32'h1C);
    rd(0, d); check("R11 I/O mode bit blocks start", d, 32'h1C);
    repeat (20) @(negedge clk);
    check("R11 no chip-select activity", 32'(cs_falls), 32'(f0));
    wr(0, 0);

    wr(64 + 20, 32'h12345678);
    wr(1, 2); wr(2, 2); wr(3, 20); wr(0, 32'hC);
    wr(64 + 20, 32'hDEADBEEF);
    wr(1, 7);
    wait_idle();
    rd(64 + 20, d); check("R13 buffer write ignored while busy", d, 32'h12345678);
    rd(1, d);       check("R13 count write ignored while busy", d, 32'd2);
    wr(0, 0);

    wr(1, 4); wr(2, 4); wr(0, 32'hC);
    repeat (10) @(negedge clk);
    rd(5, d); check("R12 state nonzero while active", 32'(d != 0), 32'd1);
    wr(4, 1);
    rd(5, d); check("R12 soft reset forces idle state", d, 32'h0);
    check("R12 soft reset raises chip select", 32'(spi_cs_n), 32'd1);
    rd(0, d); check("R12 soft reset clears in-progress", 32'(d[0]), 32'd0);
    wr(4, 0); wr(0, 0);

    wr(0, 32'hC);
    repeat (200) @(negedge clk);
    wr(0, 0);
    rd(0, d); check("R8 abort mid-transfer", d, 32'h0);
    rd(5, d); check("R8 abort state idle", d, 32'h0);
    check("R8 abort chip select high", 32'(spi_cs_n), 32'd1);

    run_vec(1, 1, 33, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule